// File: doc/BRIEF.md
# Configurable Synchronous Serial Shifter

This block is a serial engine that a processor drives through plain register-style ports. Its core is an 8-bit data register. The processor can load it and read it at any time, and the serial clock shifts it in the same place. Bits leave from the top end and enter at the bottom end. There is no separate receive holding stage, so a completed byte has to be collected before the next shift starts. A 4-bit edge counter raises an overflow flag at that point.

The register's top bit passes through a half-cycle latch before it reaches a pin. The latch is open only while the serial clock is low, so the output moves half a clock away from the sampling edge. A wire-mode field selects the pin. In three-wire mode the bit goes to a push-pull data output. In the two two-wire modes it drives an open-drain data line. Those modes also detect the bus start pattern and can stretch the clock by pulling the clock line low.

The shift clock comes from one of three sources: the external clock pin, a timer compare pulse or a software strobe. Each pulse from the timer or the strobe counts as one clock edge. Edges alternate between sampling and output update.

Top module: `sershift_top`

## Requirements
- R1: After reset the data register and the counter read 0. Both flags and both interrupt outputs are 0. `dout_pin`, `sda_pull_low`, `scl_pull_low` and `sclk_out` are all 0.
- R2: On each sampling (rising) serial clock edge, the data register shifts one place toward its top bit and takes the synchronized `din_pin` level into bit 0. Bits therefore leave most significant first, and after 8 sampling edges the register holds the received byte.
- R3: The counter advances on both serial clock edges. The edge that moves it from 15 to 0 sets the overflow flag. A counter write from the processor preloads it, so a value of 14 gives a 1-bit transfer.
- R4: The output bit follows the register's top bit only while the serial clock level is low. During the high phase it keeps the value it had before the sampling edge.
- R5: `mode_sel` encodes the wire mode: 0 off, 1 three-wire, 2 two-wire, 3 two-wire with hold on overflow. In mode 1 `dout_pin` carries the output bit. In modes 2 and 3 `dout_pin` is 0, and `sda_pull_low` is 1 exactly when `out_en` is 1 and the output bit is 0.
- R6: In modes 2 and 3, a falling edge on the data line while the clock line is high sets the start flag. A falling edge while the clock is low does not set it, and neither does the same pattern in mode 1.
- R7: Each flag stays set until a 1-cycle pulse on its clear input. `ovf_irq` equals the overflow flag AND `ovf_ie`. `start_irq` equals the start flag AND `start_ie`.
- R8: `scl_pull_low` is 1 in modes 2 and 3 while the start flag is set, and in mode 3 also while the overflow flag is set. It is 0 otherwise.
- R9: `clk_src` encodes the clock source: 0 the clock pin, 1 the timer pulse, 2 the software strobe. When 1 or 2 is selected, each pulse of that input is one edge, alternating sampling and update. A pulse on the source that is not selected has no effect.
- R10: In mode 0, serial clock edges neither shift the register nor move the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Wire mode (0 off, 1 three-wire, 2 two-wire, 3 two-wire hold on overflow) |
| clk_src | input | 2 | Clock source (0 pin, 1 timer pulse, 2 software strobe) |
| out_en | input | 1 | Enables the open-drain data driver |
| ovf_ie | input | 1 | Overflow interrupt enable |
| start_ie | input | 1 | Start interrupt enable |
| dr_we | input | 1 | Data register write strobe |
| dr_wdata | input | 8 | Data register write value |
| dr_rdata | output | 8 | Data register contents |
| cnt_we | input | 1 | Counter preload strobe |
| cnt_wdata | input | 4 | Counter preload value |
| cnt_value | output | 4 | Counter contents |
| ovf_clr | input | 1 | Overflow flag clear pulse |
| start_clr | input | 1 | Start flag clear pulse |
| ovf_flag | output | 1 | Counter overflow flag |
| start_flag | output | 1 | Start-condition flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| start_irq | output | 1 | Start interrupt request |
| timer_pulse | input | 1 | Timer compare pulse clock source |
| soft_strobe | input | 1 | Software clock strobe |
| sclk_pin | input | 1 | Serial clock pin level (SCL in two-wire modes) |
| din_pin | input | 1 | Serial data input (the shared data line in two-wire modes) |
| dout_pin | output | 1 | Three-wire data output |
| sda_pull_low | output | 1 | Pulls the open-drain data line low |
| scl_pull_low | output | 1 | Pulls the clock line low (clock hold) |
| sclk_out | output | 1 | Internal clock level for driving a serial clock as master |

## Verification
The bench probes the half-cycle latch by reading the output just after each rising edge. A design that let the latch pass through during the high phase would show the next bit too early. It runs the counter across its wrap and preloads it near the end. A design whose overflow fired one edge early, or that counted only one edge per bit, would set the flag at the wrong time. Start detection is exercised with the data line falling while the clock is low and in three-wire mode, where a detector that ignored the clock level or the mode would set the flag. It also checks that clock hold responds to overflow only in mode 3, and that pulses from a clock source that is not selected leave the counter unchanged.

// File: rtl/sershift_pkg.sv
package sershift_pkg;
   typedef enum logic [1:0] {
      WM_OFF       = 2'd0,
      WM_THREE     = 2'd1,
      WM_TWO       = 2'd2,
      WM_TWO_HOLD  = 2'd3
   } wire_mode_e;

   typedef enum logic [1:0] {
      CS_PIN    = 2'd0,
      CS_TIMER  = 2'd1,
      CS_SOFT   = 2'd2,
      CS_NONE   = 2'd3
   } clk_src_e;
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
   parameter int            STAGES  = 2,
   parameter int            W       = 1,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("ss_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[0] <= RST_VAL;
         else        chain[0] <= d;
      end
      for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[gi] <= RST_VAL;
            else        chain[gi] <= chain[gi-1];
         end
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/ss_clkgen.sv
module ss_clkgen
   import sershift_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  src,
   input  logic        enable,
   input  logic        pin_lvl,
   input  logic        timer_pulse,
   input  logic        soft_strobe,
   output logic        lvl,
   output logic        int_lvl,
   output logic        samp_edge,
   output logic        upd_edge
);
   clk_src_e src_e;
   logic     pin_d;
   logic     pulse;
   logic     raw_rise;
   logic     raw_fall;

   assign src_e = clk_src_e'(src);

   always_comb begin
      unique case (src_e)
         CS_TIMER: pulse = timer_pulse;
         CS_SOFT:  pulse = soft_strobe;
         default:  pulse = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_d   <= 1'b1;
         int_lvl <= 1'b0;
      end else begin
         pin_d <= pin_lvl;
         if (pulse && enable) int_lvl <= ~int_lvl;
      end
   end

   always_comb begin
      if (src_e == CS_PIN) begin
         lvl      = pin_lvl;
         raw_rise = pin_lvl & ~pin_d;
         raw_fall = ~pin_lvl & pin_d;
      end else begin
         lvl      = int_lvl;
         raw_rise = pulse & ~int_lvl;
         raw_fall = pulse & int_lvl;
      end
   end

   assign samp_edge = enable & raw_rise;
   assign upd_edge  = enable & raw_fall;
endmodule

// File: rtl/ss_counter.sv
module ss_counter #(
   parameter int CNT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_val,
   input  logic              clr,
   output logic [CNT_W-1:0]  cnt,
   output logic              flag
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic wrap;
   assign wrap = step & ~load & (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         if (load)      cnt <= load_val;
         else if (step) cnt <= cnt + 1'b1;
         if (wrap)      flag <= 1'b1;
         else if (clr)  flag <= 1'b0;
      end
   end
endmodule

// File: rtl/ss_startdet.sv
module ss_startdet (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic scl_lvl,
   input  logic sda_lvl,
   input  logic clr,
   output logic flag
);
   logic sda_d;
   logic hit;

   assign hit = enable & sda_d & ~sda_lvl & scl_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_d <= 1'b1;
         flag  <= 1'b0;
      end else begin
         sda_d <= sda_lvl;
         if (hit)      flag <= 1'b1;
         else if (clr) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/sershift_top.sv
module sershift_top
   import sershift_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic [1:0]        clk_src,
   input  logic              out_en,
   input  logic              ovf_ie,
   input  logic              start_ie,
   input  logic              dr_we,
   input  logic [DATA_W-1:0] dr_wdata,
   output logic [DATA_W-1:0] dr_rdata,
   input  logic              cnt_we,
   input  logic [CNT_W-1:0]  cnt_wdata,
   output logic [CNT_W-1:0]  cnt_value,
   input  logic              ovf_clr,
   input  logic              start_clr,
   output logic              ovf_flag,
   output logic              start_flag,
   output logic              ovf_irq,
   output logic              start_irq,
   input  logic              timer_pulse,
   input  logic              soft_strobe,
   input  logic              sclk_pin,
   input  logic              din_pin,
   output logic              dout_pin,
   output logic              sda_pull_low,
   output logic              scl_pull_low,
   output logic              sclk_out
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("sershift_top: DATA_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("sershift_top: CNT_W must be at least 1");
   end

   wire_mode_e   mode;
   logic         three_w;
   logic         two_w;
   logic         active;
   logic [1:0]   pins_s;
   logic         scl_s;
   logic         din_s;
   logic         ser_lvl;
   logic         samp_edge;
   logic         upd_edge;
   logic [MSB:0] dr;
   logic         out_bit;

   assign mode    = wire_mode_e'(mode_sel);
   assign three_w = (mode == WM_THREE);
   assign two_w   = (mode == WM_TWO) || (mode == WM_TWO_HOLD);
   assign active  = (mode != WM_OFF);

   ss_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (2),
      .RST_VAL (2'b11)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk_pin, din_pin}),
      .q     (pins_s)
   );
   assign scl_s = pins_s[1];
   assign din_s = pins_s[0];

   ss_clkgen u_clkgen (
      .clk         (clk),
      .rst_n       (rst_n),
      .src         (clk_src),
      .enable      (active),
      .pin_lvl     (scl_s),
      .timer_pulse (timer_pulse),
      .soft_strobe (soft_strobe),
      .lvl         (ser_lvl),
      .int_lvl     (sclk_out),
      .samp_edge   (samp_edge),
      .upd_edge    (upd_edge)
   );

   ss_counter #(.CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (samp_edge | upd_edge),
      .load     (cnt_we),
      .load_val (cnt_wdata),
      .clr      (ovf_clr),
      .cnt      (cnt_value),
      .flag     (ovf_flag)
   );

   ss_startdet u_startdet (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (two_w),
      .scl_lvl (scl_s),
      .sda_lvl (din_s),
      .clr     (start_clr),
      .flag    (start_flag)
   );

   // Shared shift register: processor write wins over a serial shift.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dr <= '0;
      else if (dr_we)     dr <= dr_wdata;
      else if (samp_edge) dr <= {dr[MSB-1:0], din_s};
   end

   // Half-cycle latch: transparent while the serial clock is low.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_bit <= 1'b0;
      else if (!ser_lvl) out_bit <= dr[MSB];
   end

   assign dr_rdata     = dr;
   assign dout_pin     = three_w & out_bit;
   assign sda_pull_low = two_w & out_en & ~out_bit;
   assign scl_pull_low = two_w & (start_flag | ((mode == WM_TWO_HOLD) & ovf_flag));
   assign ovf_irq      = ovf_flag & ovf_ie;
   assign start_irq    = start_flag & start_ie;
endmodule

// File: rtl/sershift_checker.sv
module sershift_checker #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_sel,
   input logic             out_en,
   input logic [CNT_W-1:0] cnt_value,
   input logic             cnt_we,
   input logic             ovf_flag,
   input logic             start_flag,
   input logic             sda_pull_low,
   input logic             scl_pull_low,
   input logic             dout_pin,
   input logic             lvl,
   input logic             out_bit
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   p_ovf_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ($past(cnt_value) == CMAX) && (cnt_value == '0));

   p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lvl) |-> $stable(out_bit));

   p_od_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull_low |-> (mode_sel[1] && out_en));

   p_dout_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel != 2'd1) |-> !dout_pin);

   p_start_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_flag) |-> $past(mode_sel[1]));

   p_hold_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_pull_low |-> (mode_sel[1] && (start_flag || ovf_flag)));

   p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode_sel == 2'd0 && !cnt_we) |-> $stable(cnt_value));
endmodule

bind sershift_top sershift_checker #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_sel     (mode_sel),
   .out_en       (out_en),
   .cnt_value    (cnt_value),
   .cnt_we       (cnt_we),
   .ovf_flag     (ovf_flag),
   .start_flag   (start_flag),
   .sda_pull_low (sda_pull_low),
   .scl_pull_low (scl_pull_low),
   .dout_pin     (dout_pin),
   .lvl          (ser_lvl),
   .out_bit      (out_bit)
);

// File: tb/sershift_top_bench.sv
module sershift_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'd0;
   logic [1:0] clk_src = 2'd0;
   logic       out_en = 1'b0, ovf_ie = 1'b0, start_ie = 1'b0;
   logic       dr_we = 1'b0;
   logic [7:0] dr_wdata = 8'h00;
   logic [7:0] dr_rdata;
   logic       cnt_we = 1'b0;
   logic [3:0] cnt_wdata = 4'h0;
   logic [3:0] cnt_value;
   logic       ovf_clr = 1'b0, start_clr = 1'b0;
   logic       ovf_flag, start_flag, ovf_irq, start_irq;
   logic       timer_pulse = 1'b0, soft_strobe = 1'b0;
   logic       sclk_pin, din_pin, dout_pin, sda_pull_low, scl_pull_low, sclk_out;
   logic       m_scl = 1'b0, m_sda = 1'b1, m_din = 1'b0, tw = 1'b0;
   int         checks = 0, failures = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   assign sclk_pin = m_scl & ~scl_pull_low;
   assign din_pin  = tw ? (m_sda & ~sda_pull_low) : m_din;

   sershift_top u_sershift_top (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .clk_src(clk_src),
      .out_en(out_en), .ovf_ie(ovf_ie), .start_ie(start_ie),
      .dr_we(dr_we), .dr_wdata(dr_wdata), .dr_rdata(dr_rdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_value(cnt_value),
      .ovf_clr(ovf_clr), .start_clr(start_clr), .ovf_flag(ovf_flag),
      .start_flag(start_flag), .ovf_irq(ovf_irq), .start_irq(start_irq),
      .timer_pulse(timer_pulse), .soft_strobe(soft_strobe),
      .sclk_pin(sclk_pin), .din_pin(din_pin), .dout_pin(dout_pin),
      .sda_pull_low(sda_pull_low), .scl_pull_low(scl_pull_low),
      .sclk_out(sclk_out)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic write_dr(input logic [7:0] v);
      @(negedge clk); dr_we = 1'b1; dr_wdata = v;
      @(negedge clk); dr_we = 1'b0;
   endtask

   task automatic load_cnt(input logic [3:0] v);
      @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
      @(negedge clk); cnt_we = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk); ovf_clr = 1'b1; start_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0; start_clr = 1'b0;
   endtask

   task automatic pulse_strobe();
      @(negedge clk); soft_strobe = 1'b1;
      @(negedge clk); soft_strobe = 1'b0;
      settle();
   endtask

   task automatic pulse_timer();
      @(negedge clk); timer_pulse = 1'b1;
      @(negedge clk); timer_pulse = 1'b0;
      settle();
   endtask

   task automatic t_reset();
      chk("R1", "dr", dr_rdata, 8'h00);
      chk("R1", "cnt", cnt_value, 4'h0);
      chk("R1", "flags", {ovf_flag, start_flag, ovf_irq, start_irq}, 4'h0);
      chk("R1", "pins", {dout_pin, sda_pull_low, scl_pull_low, sclk_out}, 4'h0);
   endtask

   task automatic t_three_wire_byte();
      logic [7:0] tx = 8'hA5;
      logic [7:0] rx = 8'h3C;
      tw = 1'b0; m_scl = 1'b0; mode_sel = 2'd1; clk_src = 2'd0;
      settle();
      load_cnt(4'h0);
      clear_flags();
      write_dr(tx);
      settle();
      for (int i = 0; i < 8; i++) begin
         m_din = rx[7-i];
         settle();
         chk("R2", "dout before sample", dout_pin, tx[7-i]);
         m_scl = 1'b1;
         settle();
         chk("R4", "dout held in high phase", dout_pin, tx[7-i]);
         if (i == 7) begin
            chk("R3", "cnt before last edge", cnt_value, 4'hF);
            chk("R3", "no early overflow", ovf_flag, 1'b0);
         end
         m_scl = 1'b0;
         settle();
      end
      chk("R2", "received byte", dr_rdata, rx);
      chk("R3", "cnt wrapped", cnt_value, 4'h0);
      chk("R3", "overflow set", ovf_flag, 1'b1);
   endtask

   task automatic t_preload_and_irq();
      clear_flags();
      chk("R7", "ovf cleared", ovf_flag, 1'b0);
      load_cnt(4'hE);
      m_scl = 1'b1; settle();
      chk("R3", "no ovf after one edge", ovf_flag, 1'b0);
      m_scl = 1'b0; settle();
      chk("R3", "ovf after short transfer", ovf_flag, 1'b1);
      chk("R7", "irq masked", ovf_irq, 1'b0);
      ovf_ie = 1'b1; settle();
      chk("R7", "irq enabled", ovf_irq, 1'b1);
      chk("R7", "flag still set", ovf_flag, 1'b1);
      clear_flags(); settle();
      chk("R7", "irq after clear", ovf_irq, 1'b0);
      ovf_ie = 1'b0;
   endtask

   task automatic t_clock_sources();
      clk_src = 2'd2; m_din = 1'b1; settle();
      load_cnt(4'h0);
      write_dr(8'h81);
      pulse_strobe();
      chk("R9", "strobe sample shifts", dr_rdata, 8'h03);
      chk("R9", "sclk_out high", sclk_out, 1'b1);
      pulse_strobe();
      chk("R9", "strobe update keeps data", dr_rdata, 8'h03);
      chk("R9", "two strobe edges", cnt_value, 4'h2);
      pulse_timer();
      chk("R9", "timer ignored", cnt_value, 4'h2);
      m_scl = 1'b1; settle(); m_scl = 1'b0; settle();
      chk("R9", "pin ignored", cnt_value, 4'h2);
      clk_src = 2'd1; settle();
      pulse_timer();
      chk("R9", "timer counts", cnt_value, 4'h3);
      chk("R9", "timer sample shifts", dr_rdata, 8'h07);
      pulse_strobe();
      chk("R9", "strobe ignored", cnt_value, 4'h3);
      pulse_timer();
   endtask

   task automatic t_mode_off();
      clk_src = 2'd0; mode_sel = 2'd0; settle();
      load_cnt(4'h5);
      write_dr(8'h5A);
      m_din = 1'b1;
      for (int i = 0; i < 3; i++) begin
         m_scl = 1'b1; settle(); m_scl = 1'b0; settle();
      end
      chk("R10", "cnt frozen", cnt_value, 4'h5);
      chk("R10", "dr frozen", dr_rdata, 8'h5A);
   endtask

   task automatic t_two_wire();
      m_scl = 1'b1; m_sda = 1'b1; tw = 1'b1;
      mode_sel = 2'd2; out_en = 1'b1; settle();
      write_dr(8'h40); settle();
      chk("R5", "pull on zero bit", sda_pull_low, 1'b1);
      chk("R5", "dout idle in two-wire", dout_pin, 1'b0);
      out_en = 1'b0; settle();
      chk("R5", "no pull without enable", sda_pull_low, 1'b0);
      out_en = 1'b1;
      write_dr(8'h80); settle();
      chk("R5", "release on one bit", sda_pull_low, 1'b0);
      clear_flags(); settle();
      start_ie = 1'b1;
      m_sda = 1'b0; settle();
      chk("R6", "start detected", start_flag, 1'b1);
      chk("R7", "start irq", start_irq, 1'b1);
      chk("R8", "hold on start", scl_pull_low, 1'b1);
      clear_flags(); settle();
      chk("R7", "start cleared", start_flag, 1'b0);
      chk("R8", "hold released", scl_pull_low, 1'b0);
      m_scl = 1'b0; settle(); m_sda = 1'b1; settle(); m_sda = 1'b0; settle();
      chk("R6", "no start with clock low", start_flag, 1'b0);
      m_sda = 1'b1; settle(); m_scl = 1'b1; settle();
      tw = 1'b0; m_din = 1'b1; mode_sel = 2'd1; settle();
      m_din = 1'b0; settle();
      chk("R6", "no start in three-wire", start_flag, 1'b0);
      start_ie = 1'b0;
   endtask

   task automatic t_hold_on_ovf();
      tw = 1'b1; m_sda = 1'b1; m_scl = 1'b1; mode_sel = 2'd2; settle();
      clear_flags();
      load_cnt(4'hF);
      m_scl = 1'b0; settle();
      chk("R3", "wrap on falling edge", ovf_flag, 1'b1);
      chk("R8", "mode 2 ignores ovf", scl_pull_low, 1'b0);
      mode_sel = 2'd3; settle();
      chk("R8", "mode 3 holds on ovf", scl_pull_low, 1'b1);
      clear_flags(); settle();
      chk("R8", "hold released on clear", scl_pull_low, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_three_wire_byte();
      t_preload_and_irq();
      t_clock_sources();
      t_mode_off();
      t_two_wire();
      t_hold_on_ovf();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         finish_run();
      end
   end
endmodule